// File: doc/BRIEF.md
# SPI Slave Byte Port with Status Handshake

This block is the receive/transmit end of a byte-wide SPI link. An external master drives the serial clock, the active-low select and the master-to-slave data line. The block answers on the slave-to-master line. A host processor reaches the block through a small register port with three addresses: a data register, a status register and a control register. A host write to the data register loads the byte that goes out on the next transfer. When eight bits have been exchanged, the received byte is placed in a receive buffer, a completion flag goes high and an interrupt may be raised.

The completion flag takes two steps to clear: a status read while a flag is set, then a data read. Until the status read happens, data writes are dropped. A second completion that arrives before the host clears the flag is an overrun. A data write made while a byte is on the wire is a write collision. All serial inputs are brought into the system clock domain through two-stage synchronisers, so the serial clock must run at no more than a quarter of the system clock rate.

Register map: address 0 is data, address 1 is status (bit 0 done, bit 1 overrun, bit 2 collision), and address 2 is control (bit 0 phase, bit 1 polarity, bit 2 interrupt enable, bits 4:3 rate field). Address 3 reads as zero.

Top module: `spi_slave`

## Requirements
- R1: After reset, status, control and data all read 0, irq is low and miso is low.
- R2: In each of the four modes, the slave returns a loaded byte MSB first on miso and takes in the master's byte MSB first from mosi. The modes are control bit 1 (idle level of sck) and control bit 0 (0: sample on the leading edge, 1: sample on the trailing edge).
- R3: The rate field (control bits 4:3) is stored and reads back unchanged. It has no effect on transfers.
- R4: After the eighth bit, status bit 0 is set and a data read returns the byte received.
- R5: irq equals status bit 0 AND control bit 2 AND NOT irq_mask.
- R6: Status bit 0 is cleared by a status read made while it is set, followed by a data read. A data read on its own leaves it set.
- R7: A data write made while status bit 0 is set, with no status read since, is ignored and does not set status bit 2.
- R8: If a transfer completes while status bit 0 is still set, status bit 1 is set and the buffer keeps the first byte. Bit 1 clears by the same sequence as in R6.
- R9: A data write is dropped and status bit 2 is set in two cases. With phase 0, the write is made while ss_n is low. With phase 1, the write is made between the first leading edge and the completion of a byte.
- R10: Status bit 2 is cleared by a status read followed by a data read or a data write.
- R11: With phase 1, a data write made while ss_n stays low between bytes is accepted.
- R12: Raising ss_n in the middle of a byte aborts it. No completion is flagged, and the next byte starts again from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks irq |
| irq | output | 1 | Interrupt request |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |

## Verification
A register access takes effect at the clock edge inside the access cycle. The bench therefore drives each access at a falling edge and updates its reference model just after the next rising edge. It compares irq with the model a quarter period after every rising edge. A serial edge reaches the shift register about three system cycles after it appears on the pin: two synchroniser stages plus the edge register. The completion pulse and the flag add two more cycles. For this reason the bench master holds each half sck period for four cycles, samples miso only at the opposite half-period, and waits eight cycles after the last edge before it checks any flag. The per-clock comparison is paused during a transfer and resumes only after that settling window.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef struct packed {
        logic [1:0] rate;
        logic       ien;
        logic       cpol;
        logic       cpha;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cpol_i,
    output logic lead_o,
    output logic trail_o
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d  = sck_i;
        rise    = sck_i & ~prev_q;
        fall    = ~sck_i & prev_q;
        lead_o  = cpol_i ? fall : rise;
        trail_o = cpol_i ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpha_i,
    input  logic          sel_i,
    input  logic          lead_i,
    input  logic          trail_i,
    input  logic          mosi_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_data_i,
    output logic          miso_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic [DW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          latch;
        logic          out;
        logic          started;
        logic          done;
        logic [DW-1:0] rx;
    } sh_state_t;

    sh_state_t q, d;
    logic      bit_in;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        bit_in = cpha_i ? mosi_i : q.latch;
        if (!sel_i) begin
            d.cnt     = '0;
            d.started = 1'b0;
        end else begin
            if (lead_i) begin
                d.started = 1'b1;
                if (cpha_i) d.out   = q.sh[DW-1];
                else        d.latch = mosi_i;
            end
            if (trail_i && q.started) begin
                d.sh  = {q.sh[DW-2:0], bit_in};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(DW-1)) begin
                    d.done    = 1'b1;
                    d.rx      = {q.sh[DW-2:0], bit_in};
                    d.cnt     = '0;
                    d.started = 1'b0;
                end
            end
        end
        if (load_i) d.sh = load_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso_o = cpha_i ? q.out : q.sh[DW-1];
    assign busy_o = cpha_i ? q.started : sel_i;
    assign done_o = q.done;
    assign rx_o   = q.rx;
endmodule

// File: rtl/spi_slave.sv
module spi_slave
    import spi_slv_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          irq_mask,
    output logic          irq,
    input  logic          sck,
    input  logic          ss_n,
    input  logic          mosi,
    output logic          miso
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic          done;
        logic          ovr;
        logic          wcol;
        logic          arm;
        logic [DW-1:0] rxbuf;
    } regs_t;

    regs_t q, d;

    logic [2:0]    pins_s;
    logic          lead, trail, busy, xfer_done, load;
    logic [DW-1:0] rx_byte;
    logic          wr_data, rd_data, rd_stat, wr_ctrl;
    logic          done_w, ovr_w, wcol_w, arm_w;
    logic          unused_wdata;

    spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({sck, ss_n, mosi}), .sync_o(pins_s)
    );

    spi_slv_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_i(pins_s[2]), .cpol_i(q.ctrl.cpol),
        .lead_o(lead), .trail_o(trail)
    );

    spi_slv_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .cpha_i(q.ctrl.cpha), .sel_i(~pins_s[1]),
        .lead_i(lead), .trail_i(trail), .mosi_i(pins_s[0]),
        .load_i(load), .load_data_i(bus_wdata),
        .miso_o(miso), .busy_o(busy), .done_o(xfer_done), .rx_o(rx_byte)
    );

    always_comb begin
        d       = q;
        load    = 1'b0;
        wr_data = bus_wr && (bus_addr == ADDR_DATA);
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        rd_data = bus_rd && (bus_addr == ADDR_DATA);
        rd_stat = bus_rd && (bus_addr == ADDR_STAT);

        if (wr_ctrl) d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (rd_stat && (q.done || q.ovr || q.wcol)) d.arm = 1'b1;
        if (rd_data && q.arm) begin
            d.done = 1'b0;
            d.ovr  = 1'b0;
            d.wcol = 1'b0;
            d.arm  = 1'b0;
        end
        if (wr_data) begin
            if (q.arm) begin
                d.wcol = 1'b0;
                d.arm  = 1'b0;
            end
            if (!q.done || q.arm) begin
                if (busy) d.wcol = 1'b1;
                else      load   = 1'b1;
            end
        end
        if (xfer_done) begin
            if (d.done) d.ovr = 1'b1;
            else begin
                d.done  = 1'b1;
                d.rxbuf = rx_byte;
            end
        end

        case (bus_addr)
            ADDR_DATA: bus_rdata = q.rxbuf;
            ADDR_STAT: bus_rdata = {{(DW-3){1'b0}}, q.wcol, q.ovr, q.done};
            ADDR_CTRL: bus_rdata = {{(DW-CTRL_W){1'b0}}, q.ctrl};
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq          = q.done && q.ctrl.ien && !irq_mask;
    assign done_w       = q.done;
    assign ovr_w        = q.ovr;
    assign wcol_w       = q.wcol;
    assign arm_w        = q.arm;
    assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/spi_slave_chk.sv
module spi_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       irq,
    input logic       done,
    input logic       ovr,
    input logic       wcol,
    input logic       arm,
    input logic       xfer_done
);
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(bus_rd && bus_addr == 2'd0)) |=> done);

    p_stat_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1 && done) |=> arm);

    p_ovr_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(done));

    p_wcol_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(bus_wr && bus_addr == 2'd0 && (!done || arm)));

    p_irq_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && arm && !xfer_done) |=> !irq);
endmodule

bind spi_slave spi_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .irq(irq), .done(done_w), .ovr(ovr_w), .wcol(wcol_w),
    .arm(arm_w), .xfer_done(xfer_done)
);

// File: tb/spi_slave_test.sv
module spi_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_mask = 1'b0;
    logic       irq;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso;

    int n_chk = 0, n_err = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // reference model state
    bit       m_done, m_ovr, m_wcol, m_arm, m_busy;
    bit [4:0] m_ctrl;
    bit [7:0] m_rx;

    always #10 clk = ~clk;

    spi_slave uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_mask(irq_mask), .irq(irq), .sck(sck), .ss_n(ss_n),
        .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (cmp_en && !finished)
            chk("R5 irq per-clock", irq, m_done && m_ctrl[2] && !irq_mask);
    end

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        logic [7:0] exp;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        case (a)
            2'd0:    exp = m_rx;
            2'd1:    exp = {5'd0, m_wcol, m_ovr, m_done};
            2'd2:    exp = {3'd0, m_ctrl};
            default: exp = 8'd0;
        endcase
        chk("R1 model read", v, exp);
        @(posedge clk); #1;
        if (a == 2'd0 && m_arm) begin
            m_done = 0; m_ovr = 0; m_wcol = 0; m_arm = 0;
        end
        if (a == 2'd1 && (m_done || m_ovr || m_wcol)) m_arm = 1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); #1;
        if (a == 2'd2) m_ctrl = v[4:0];
        if (a == 2'd0) begin
            bit was_armed = m_arm;
            if (m_arm) begin m_wcol = 0; m_arm = 0; end
            if (!m_done || was_armed) if (m_busy) m_wcol = 1;
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit keep_low,
                        output logic [7:0] got);
        bit cpol, cpha;
        cpol = m_ctrl[1]; cpha = m_ctrl[0];
        cmp_en = 1'b0;
        got = 8'd0;
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) mosi = tx[7-i];
            repeat (4) @(negedge clk);
            sck = ~cpol;
            if (cpha) mosi = tx[7-i];
            else got[7-i] = miso;
            repeat (4) @(negedge clk);
            sck = cpol;
            if (cpha) got[7-i] = miso;
        end
        repeat (4) @(negedge clk);
        if (!keep_low) ss_n = 1'b1;
        repeat (8) @(negedge clk);
        if (nbits == 8) begin
            if (m_done) m_ovr = 1;
            else begin m_rx = tx; m_done = 1; end
        end
        cmp_en = 1'b1;
    endtask

    task automatic set_mode(input logic [7:0] c);
        bus_write(2'd2, c);
        sck = c[1];
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v, got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;

        // R1 reset state
        bus_read(2'd1, v); chk("R1 status", v, 8'h00);
        bus_read(2'd0, v); chk("R1 data", v, 8'h00);
        bus_read(2'd2, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 miso", miso, 1'b0);

        // R2 R3 R4 R5 R6: four modes with distinct rate fields
        for (int m = 0; m < 4; m++) begin
            logic [7:0] c, tx, mo;
            c  = 8'((m << 3) | 4 | m);
            tx = 8'h96 ^ 8'(m * 8'h11);
            mo = 8'h3A + 8'(m * 7);
            set_mode(c);
            bus_read(2'd2, v); chk("R3 rate field readback", v, c);
            bus_write(2'd0, tx);
            xfer(mo, 8, 1'b0, got);
            chk("R2 miso byte", got, tx);
            chk("R5 irq after completion", irq, 1'b1);
            bus_read(2'd1, v); chk("R4 done flag", v, 8'h01);
            bus_read(2'd0, v); chk("R4 received byte", v, mo);
            bus_read(2'd1, v); chk("R6 cleared", v, 8'h00);
        end

        // R6 data read alone, R5 mask gating
        set_mode(8'h04);
        bus_write(2'd0, 8'h10);
        xfer(8'h5A, 8, 1'b0, got);
        bus_read(2'd0, v); chk("R6 data read value", v, 8'h5A);
        bus_read(2'd1, v); chk("R6 flag kept without status read", v, 8'h01);
        // that status read armed; re-arm not needed, but test inhibit first needs unarmed: clear then redo
        bus_read(2'd0, v);
        xfer(8'h5A, 8, 1'b0, got);
        irq_mask = 1'b1;
        @(negedge clk); chk("R5 masked irq", irq, 1'b0);
        irq_mask = 1'b0;
        @(negedge clk); chk("R5 unmasked irq", irq, 1'b1);

        // R7 inhibited write, R8 overrun
        bus_write(2'd0, 8'h3C);
        xfer(8'h11, 8, 1'b0, got);
        chk("R7 ignored write not sent", got, 8'h5A);
        bus_read(2'd1, v); chk("R8 overrun flagged, R7 no collision", v, 8'h03);
        bus_read(2'd0, v); chk("R8 buffer keeps first", v, 8'h5A);
        bus_read(2'd1, v); chk("R8 overrun cleared", v, 8'h00);

        // R9 phase 0 collision, R10 clear by data read
        bus_write(2'd0, 8'h77);
        ss_n = 1'b0; m_busy = 1;
        repeat (4) @(negedge clk);
        bus_write(2'd0, 8'h99);
        bus_read(2'd1, v); chk("R9 collision phase 0", v, 8'h04);
        bus_read(2'd0, v);
        bus_read(2'd1, v); chk("R10 cleared by data read", v, 8'h00);
        m_busy = 0;
        xfer(8'h21, 8, 1'b0, got);
        chk("R9 collided write dropped", got, 8'h77);
        bus_read(2'd1, v);
        bus_read(2'd0, v);

        // R11 phase 1 between bytes, R9 mid-byte, R12 abort, R10 clear by write
        set_mode(8'h05);
        bus_write(2'd0, 8'h81);
        xfer(8'h66, 8, 1'b1, got);
        chk("R2 phase 1 with select held", got, 8'h81);
        bus_read(2'd1, v);
        bus_read(2'd0, v); chk("R4 phase 1 received", v, 8'h66);
        bus_write(2'd0, 8'h42);
        bus_read(2'd1, v); chk("R11 write between bytes accepted", v, 8'h00);
        xfer(8'hF0, 3, 1'b1, got);
        m_busy = 1;
        bus_write(2'd0, 8'hEE);
        m_busy = 0;
        ss_n = 1'b1;
        repeat (8) @(negedge clk);
        bus_read(2'd1, v); chk("R9 mid-byte collision, R12 no completion", v, 8'h04);
        bus_write(2'd0, 8'h42);
        bus_read(2'd1, v); chk("R10 cleared by data write", v, 8'h00);
        xfer(8'hC5, 8, 1'b0, got);
        chk("R12 restart from bit 7", got, 8'h42);
        bus_read(2'd1, v); chk("R12 full byte completes", v, 8'h01);
        bus_read(2'd0, v); chk("R12 received after abort", v, 8'hC5);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule